// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block is a single-master engine that writes bytes onto an I2C bus. Software reaches it through a small synchronous register port with three registers: a one-byte data buffer, a control register and a status register. When software asks for a start, the engine puts a START condition on the bus and copies the buffered byte into a shift register. It then clocks the byte out MSB first and samples the slave's acknowledge on the ninth clock. The engine does not build the address for the slave. Software writes the address bytes into the data buffer like any other byte, so 7-bit and 10-bit addressed writes differ only in how many address bytes software queues.

The buffer is freed as soon as the first bit of the current byte has been clocked out. Software therefore has most of a byte time to queue the next byte, and consecutive bytes run with no gap. An acknowledged byte with nothing queued behind it parks the bus with SCL low. A refused byte freezes the engine until software asks for STOP together with a flush. Both bus lines are open-drain: the block drives only pull-low enables and reads the line levels back through synchronizers. The interval between bus phase steps is set by the `CLK_DIV` parameter.

Top module: `i2cw_top`

## Requirements
- R1: After reset the status register (address 2) reads 0x01: buffer-empty flag (bit 0) set, and acknowledge (bit 1), refusal (bit 2) and busy (bit 3) clear. Neither line is pulled low and `irq` is low.
- R2: Control bit 0 (address 1) enables the engine. While it is 0, a start request (control bit 2) causes no bus activity and busy stays 0.
- R3: With the engine enabled, the buffer full and start requested, the engine pulls SDA low while SCL is high (START). It then sends the buffered byte MSB first and releases SDA for the ninth clock.
- R4: After a byte has been loaded into the shift register, the buffer-empty flag returns to 1 once that byte's first SCL high phase has passed, and before its second one.
- R5: SDA changes only while SCL is low, except for the START edge (falling) and the STOP edge (rising). Each bus phase step lasts `CLK_DIV` system clocks.
- R6: A byte written into the data register (address 0) before the ninth clock ends is sent next with no STOP between the two bytes. If nothing is queued, SCL is held low with busy set until a byte is written or STOP is requested.
- R7: SDA low at the ninth clock sets the acknowledge flag (bit 1). SDA high at the ninth clock sets the refusal flag (bit 2) and clears the acknowledge flag.
- R8: `irq` equals enable AND ((control bit 1 AND buffer empty) OR refusal flag).
- R9: After a refusal the engine produces no SCL activity, even if a new byte is written, until STOP is requested.
- R10: STOP (control bit 3) together with flush (control bit 4) produces a STOP condition and sets the buffer-empty flag. After the STOP the engine clears both the STOP request and the refusal flag.
- R11: A 10-bit addressed write is sent unchanged as header byte 11110·a9·a8·0, then the low address byte, then the data. It uses the same flow as a 7-bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_we | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The hardest state to reach is the frozen state after a refusal while a fresh byte sits in the buffer. Reaching it needs a slave that refuses at exactly the ninth clock, and the bench must then prove that nothing moves on the bus. The bench's slave model decodes START, STOP and the bits from the line levels, and an enable input lets it refuse on demand. After the refusal, the bench writes a new byte and checks SCL on every clock for a long window. It then issues STOP with flush and confirms that the queued byte was never sent.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_BIT, ST_HOLD, ST_FREEZE, ST_STOP
   } seq_state_t;

   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;

   localparam int CTL_EN    = 0;
   localparam int CTL_TXIE  = 1;
   localparam int CTL_START = 2;
   localparam int CTL_STOP  = 3;
   localparam int CTL_FLUSH = 4;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_thru
         assign q = d;
      end else begin : g_ff
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '1;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cw_divider.sv
module i2cw_divider #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == CW'(DIV - 1)) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
   import i2cw_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          start_req,
   input  logic          stop_req,
   input  logic          dat_full,
   input  logic [DW-1:0] dat,
   input  logic          scl_s,
   input  logic          sda_s,
   output logic          take,
   output logic          start_done,
   output logic          stop_done,
   output logic          ack_hit,
   output logic          nack_hit,
   output logic          busy,
   output logic          scl_oe,
   output logic          sda_oe
);
   localparam int BW = $clog2(DW + 1);

   seq_state_t    state;
   logic [1:0]    q;
   logic [BW-1:0] bitn;
   logic [DW-1:0] shreg;
   logic          scl_d, sda_d;
   logic          data_bit;

   assign busy     = (state != ST_IDLE);
   assign data_bit = (bitn < BW'(DW));

   always_comb begin
      scl_d = 1'b0;
      sda_d = 1'b0;
      unique case (state)
         ST_START: begin
            scl_d = (q == 2'd3);
            sda_d = (q != 2'd0);
         end
         ST_BIT: begin
            scl_d = (q < 2'd2);
            sda_d = data_bit ? ~shreg[DW-1] : 1'b0;
         end
         ST_HOLD, ST_FREEZE: scl_d = 1'b1;
         ST_STOP: begin
            scl_d = (q == 2'd0);
            sda_d = (q != 2'd3);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         q          <= '0;
         bitn       <= '0;
         shreg      <= '0;
         scl_oe     <= 1'b0;
         sda_oe     <= 1'b0;
         take       <= 1'b0;
         start_done <= 1'b0;
         stop_done  <= 1'b0;
         ack_hit    <= 1'b0;
         nack_hit   <= 1'b0;
      end else begin
         scl_oe     <= scl_d;
         sda_oe     <= sda_d;
         take       <= 1'b0;
         start_done <= 1'b0;
         stop_done  <= 1'b0;
         ack_hit    <= 1'b0;
         nack_hit   <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
            q     <= '0;
         end else begin
            unique case (state)
               ST_IDLE: if (start_req && dat_full) begin
                  state <= ST_START;
                  q     <= '0;
               end
               ST_START: if (tick) begin
                  q <= q + 1'b1;
                  if (q == 2'd3) begin
                     shreg      <= dat;
                     bitn       <= '0;
                     state      <= ST_BIT;
                     start_done <= 1'b1;
                  end
               end
               ST_BIT: if (tick && !(q == 2'd2 && !scl_s)) begin
                  q <= q + 1'b1;
                  if (q == 2'd3) begin
                     if (data_bit) begin
                        shreg <= shreg << 1;
                        bitn  <= bitn + 1'b1;
                        take  <= (bitn == '0);
                     end else if (!sda_s) begin
                        ack_hit <= 1'b1;
                        if (dat_full) begin
                           shreg <= dat;
                           bitn  <= '0;
                        end else if (stop_req) begin
                           state <= ST_STOP;
                        end else begin
                           state <= ST_HOLD;
                        end
                     end else begin
                        nack_hit <= 1'b1;
                        state    <= ST_FREEZE;
                     end
                  end
               end
               ST_HOLD: if (dat_full) begin
                  shreg <= dat;
                  bitn  <= '0;
                  q     <= '0;
                  state <= ST_BIT;
               end else if (stop_req) begin
                  q     <= '0;
                  state <= ST_STOP;
               end
               ST_FREEZE: if (stop_req) begin
                  q     <= '0;
                  state <= ST_STOP;
               end
               ST_STOP: if (tick) begin
                  q <= q + 1'b1;
                  if (q == 2'd3) begin
                     stop_done <= 1'b1;
                     state     <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2: an idle engine lets both lines float high
   assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (!scl_oe && !sda_oe));

   // R5: SDA holds still while SCL stays released inside a byte
   assert_sda_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BIT && $past(state) == ST_BIT && !scl_oe && !$past(scl_oe))
      |-> (sda_oe == $past(sda_oe)));

   // R9: a refused transfer stays frozen until STOP is requested
   assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FREEZE && en && !stop_req) |=> (state == ST_FREEZE));
endmodule

// File: rtl/i2cw_top.sv
module i2cw_top
   import i2cw_pkg::*;
#(
   parameter int CLK_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       scl_in,
   input  logic       sda_in
);
   localparam int DW = 8;

   generate
      if (CLK_DIV < 4) begin : g_div_chk
         $error("CLK_DIV must be at least 4");
      end
      if (SYNC_STAGES + 1 >= 2 * CLK_DIV) begin : g_sync_chk
         $error("SYNC_STAGES too deep for the SCL high window");
      end
   endgenerate

   logic          ctl_en, ctl_txie, req_start, req_stop;
   logic [DW-1:0] dat_reg;
   logic          dat_empty, st_ack, st_nack;
   logic          tick, take, start_done, stop_done, ack_hit, nack_hit, busy;
   logic [1:0]    pins_s;
   logic          wr_ctl, wr_dat;

   assign wr_ctl = reg_we && (reg_addr == REG_CTRL);
   assign wr_dat = reg_we && (reg_addr == REG_DATA);

   i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s));

   i2cw_divider #(.DIV(CLK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick));

   i2cw_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl_en),
      .start_req(req_start), .stop_req(req_stop), .dat_full(!dat_empty),
      .dat(dat_reg), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
      .take(take), .start_done(start_done), .stop_done(stop_done),
      .ack_hit(ack_hit), .nack_hit(nack_hit), .busy(busy),
      .scl_oe(scl_oe), .sda_oe(sda_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b0;
         ctl_txie  <= 1'b0;
         req_start <= 1'b0;
         req_stop  <= 1'b0;
         dat_reg   <= '0;
         dat_empty <= 1'b1;
         st_ack    <= 1'b0;
         st_nack   <= 1'b0;
      end else begin
         if (start_done) req_start <= 1'b0;
         if (stop_done) begin
            req_stop <= 1'b0;
            st_nack  <= 1'b0;
         end
         if (req_stop && !busy) req_stop <= 1'b0;
         if (take) dat_empty <= 1'b1;
         if (ack_hit) st_ack <= 1'b1;
         if (nack_hit) begin
            st_ack  <= 1'b0;
            st_nack <= 1'b1;
         end
         if (wr_dat) begin
            dat_reg   <= reg_wdata;
            dat_empty <= 1'b0;
         end
         if (wr_ctl) begin
            ctl_en   <= reg_wdata[CTL_EN];
            ctl_txie <= reg_wdata[CTL_TXIE];
            if (reg_wdata[CTL_START] && reg_wdata[CTL_EN]) req_start <= 1'b1;
            if (reg_wdata[CTL_STOP]) req_stop <= 1'b1;
            if (reg_wdata[CTL_FLUSH]) dat_empty <= 1'b1;
         end
      end
   end

   assign irq = ctl_en && ((ctl_txie && dat_empty) || st_nack);

   always_comb begin
      unique case (reg_addr)
         REG_DATA: reg_rdata = dat_reg;
         REG_CTRL: reg_rdata = {4'b0, req_stop, req_start, ctl_txie, ctl_en};
         REG_STAT: reg_rdata = {4'b0, busy, st_nack, st_ack, dat_empty};
         default:  reg_rdata = '0;
      endcase
   end

   // R7: acknowledge and refusal never both reported
   assert_nack_excl_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_nack |-> !st_ack);

   // R10: the refusal flag is only cleared by a finished STOP
   assert_nack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_nack) |-> $past(stop_done));

   // R4: the buffer only empties itself while a transfer runs
   assert_take_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> busy);
endmodule

// File: tb/i2cw_top_tb.sv
module i2cw_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq, scl_oe, sda_oe;
   logic       slv_low = 1'b0;
   logic       ack_en = 1'b1;
   logic       scl_ln, sda_ln;

   int n_tests = 0;
   int n_fail  = 0;
   int rc = 0;
   int n_start = 0;
   int n_stop  = 0;
   logic [7:0] sh = 8'h00;
   logic [7:0] rxq[$];
   logic [7:0] expq[$];
   logic prev_scl = 1'b1;
   logic prev_sda = 1'b1;

   always #2 clk = ~clk;

   assign scl_ln = ~scl_oe;
   assign sda_ln = ~(sda_oe | slv_low);

   i2cw_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_ln), .sda_in(sda_ln));

   // behavioural slave and bus decoder
   always @(posedge clk) begin
      if (rst_n) begin
         if (scl_ln && prev_scl && (sda_ln != prev_sda)) begin
            if (!sda_ln) begin n_start++; rc = 0; end
            else n_stop++;
         end else if (scl_ln && !prev_scl) begin
            if (rc < 8) sh = {sh[6:0], sda_ln};
            rc++;
            if (rc == 8) rxq.push_back(sh);
         end else if (!scl_ln && prev_scl) begin
            if (rc == 8) slv_low <= ack_en;
            else begin
               slv_low <= 1'b0;
               if (rc >= 9) rc = 0;
            end
         end
      end
      prev_scl = scl_ln;
      prev_sda = sda_ln;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_stat(input int b, input logic val, input string req);
      logic [7:0] v;
      int k;
      k = 0;
      rd(2'd2, v);
      while (v[b] !== val && k < 5000) begin rd(2'd2, v); k++; end
      chk(req, {31'd0, v[b]}, {31'd0, val});
   endtask

   task automatic scl_quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(req, {31'd0, scl_ln}, 32'd0);
      end
   endtask

   task automatic chk_rx(input string req);
      chk(req, rxq.size(), expq.size());
      for (int i = 0; i < expq.size() && i < rxq.size(); i++)
         chk(req, {24'd0, rxq[i]}, {24'd0, expq[i]});
      rxq.delete();
      expq.delete();
   endtask

   // write several bytes; each new byte queued after the buffer empties
   task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int nb);
      int st0;
      st0 = n_stop;
      expq.push_back(b0);
      wr(2'd0, b0);
      wr(2'd1, 8'h05);
      wait_stat(0, 1'b1, "R4 empty after first bit");
      chk("R4 empty between first and second SCL high", rc, 1);
      if (nb > 1) begin
         expq.push_back(b1);
         wr(2'd0, b1);
         wait_stat(0, 1'b1, "R6 second byte taken");
         chk("R4 second byte early empty", rc, 1);
      end
      if (nb > 2) begin
         expq.push_back(b2);
         wr(2'd0, b2);
         wait_stat(0, 1'b1, "R6 third byte taken");
      end
      wr(2'd1, 8'h09);
      wait_stat(3, 1'b0, "R10 busy drops after STOP");
      chk("R10 one STOP seen", n_stop - st0, 1);
   endtask

   initial begin
      logic [7:0] v;
      int s0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd2, v);
      chk("R1 status after reset", v, 8'h01);
      chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
      chk("R1 irq low", irq, 1'b0);

      // R8 interrupt gating
      wr(2'd1, 8'h03);
      #1 chk("R8 irq with txie and empty", irq, 1'b1);
      wr(2'd1, 8'h01);
      #1 chk("R8 irq off without txie", irq, 1'b0);

      // R3 R6 R7: 7-bit write, three bytes back to back
      ack_en = 1'b1;
      s0 = n_start;
      send(8'hA4, 8'h3C, 8'h81, 3);
      chk_rx("R3 R6 bytes on the bus");
      chk("R6 single START for three bytes", n_start - s0, 1);
      rd(2'd2, v);
      chk("R7 ack flag set", v[1], 1'b1);
      rd(2'd1, v);
      chk("R10 stop request cleared", v[3], 1'b0);

      // R6 hold: acknowledged byte with nothing queued
      expq.push_back(8'h55);
      wr(2'd0, 8'h55);
      wr(2'd1, 8'h05);
      wait_stat(0, 1'b1, "R4 hold byte taken");
      repeat (400) @(negedge clk);
      rd(2'd2, v);
      chk("R6 busy while parked", v[3], 1'b1);
      scl_quiet(200, "R6 SCL held low while parked");
      expq.push_back(8'h66);
      wr(2'd0, 8'h66);
      wait_stat(0, 1'b1, "R6 resumed after write");
      wr(2'd1, 8'h09);
      wait_stat(3, 1'b0, "R6 stop after resume");
      chk_rx("R6 parked then resumed bytes");

      // R7 R9 R10: refusal, freeze, stop with flush
      ack_en = 1'b0;
      s0 = n_stop;
      expq.push_back(8'h90);
      wr(2'd0, 8'h90);
      wr(2'd1, 8'h05);
      wait_stat(2, 1'b1, "R7 refusal flag set");
      rd(2'd2, v);
      chk("R7 ack cleared on refusal", v[1], 1'b0);
      chk("R8 irq from refusal", irq, 1'b1);
      repeat (40) @(negedge clk);
      wr(2'd0, 8'h11);
      scl_quiet(400, "R9 frozen after refusal");
      wr(2'd1, 8'h19);
      wait_stat(3, 1'b0, "R10 idle after stop");
      rd(2'd2, v);
      chk("R10 refusal cleared and buffer flushed", v, 8'h01);
      rd(2'd1, v);
      chk("R10 stop request self-cleared", v[3], 1'b0);
      chk("R10 STOP on bus", n_stop - s0, 1);
      chk_rx("R9 queued byte never sent");

      // R11: 10-bit address 0x2B7
      ack_en = 1'b1;
      send(8'hF4, 8'hB7, 8'hE1, 3);
      chk_rx("R11 10-bit header, low address, data");

      // R2: disabled engine ignores start
      wr(2'd1, 8'h00);
      s0 = n_start;
      wr(2'd0, 8'h12);
      wr(2'd1, 8'h04);
      repeat (20) @(negedge clk);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         chk("R2 lines idle while disabled", {scl_ln, sda_ln}, 2'b11);
      end
      rd(2'd2, v);
      chk("R2 not busy when disabled", v[3], 1'b0);
      chk("R2 no START when disabled", n_start - s0, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule